// File: doc/BRIEF.md
# DMA Transaction and Burst Splitter

This block turns one DMA data movement between an on-chip FIFO and system memory into a series of system-bus burst requests. A single start pulse brings in a word-aligned start address, a length in 32-bit words and a direction. In the receive direction, data leaves the receive FIFO and is written to memory. In the transmit direction, data is read from memory to fill the transmit FIFO. The programmed sizes are captured at the start pulse and stay fixed for the whole movement.

The movement is processed one transaction at a time. A receive transaction starts only when the receive FIFO holds a full transaction, or when the frame has ended and whatever data is left can be flushed. A transmit transaction starts only when the transmit FIFO has room for all of it. Inside a transaction, each burst is cut to the shortest of three limits: the words left in the transaction, the burst limit for that direction, and the words left before the next 1 KB address boundary. Only one burst request is outstanding at a time, on a ready/valid handshake. When the last word has been requested, the block raises a one-cycle done pulse.

Top module: `dma_burst_splitter`

## Requirements
- R1: While reset is asserted and after it is released, req_valid, busy and done are all 0 until a start pulse arrives.
- R2: The effective transaction size is the captured setting clamped into the range 1 to the FIFO depth: 64 words for receive and 32 words for transmit. The receive direction (to_mem=1) uses the write burst setting and the transmit direction uses the read burst setting. That burst setting is clamped the same way and then reduced to the transaction size. Oversized settings are legal, and no request ever exceeds the resulting limit.
- R3: Each burst length equals the minimum of the words left in the transaction, the burst limit, and (1024 − (address mod 1024)) / 4. No burst crosses a 1 KB boundary.
- R4: Address bits [1:0] of start_addr are treated as 0. The first request carries that address, and each later request begins 4 × (previous length) bytes after the previous one.
- R5: In receive, a transaction starts when rx_level ≥ the transaction size, with length min(words left, size). Otherwise, while rx_eof is 1 and rx_level is non-zero, it starts with length min(words left, rx_level). Otherwise no request is made.
- R6: In transmit, a transaction has length min(words left, size) and starts only when tx_free ≥ that length.
- R7: While req_valid is 1 and req_ready is 0, req_valid, req_addr and req_len hold their values. req_write equals the captured to_mem.
- R8: If a transaction's start condition is true at clock edge t, req_valid rises after edge t+1. After an accept at edge t, if words remain in the transaction, the next request is valid after edge t+1, so there is one idle cycle between requests.
- R9: done is a single-cycle pulse that appears after the edge where the final burst is accepted. The request lengths sum to the programmed length.
- R10: A start with length 0 makes no request and pulses done after the start edge.
- R11: A start pulse while busy is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted only when idle |
| to_mem | input | 1 | 1 = receive (FIFO to memory, bus write), 0 = transmit |
| start_addr | input | ADDR_W | Byte start address (low two bits ignored) |
| length | input | LEN_W | Length of the movement in 32-bit words |
| cfg_rd_burst | input | CFG_W | Read burst maximum in words |
| cfg_wr_burst | input | CFG_W | Write burst maximum in words |
| cfg_rx_txn | input | CFG_W | Receive transaction size in words |
| cfg_tx_txn | input | CFG_W | Transmit transaction size in words |
| rx_level | input | CFG_W | Words held in the receive FIFO |
| rx_eof | input | 1 | Frame end reached; remaining data may be flushed |
| tx_free | input | CFG_W | Free words in the transmit FIFO |
| req_valid | output | 1 | Burst request valid |
| req_ready | input | 1 | Burst request accepted |
| req_addr | output | ADDR_W | Burst byte address |
| req_len | output | CFG_W | Burst length in words |
| req_write | output | 1 | 1 = bus write, 0 = bus read |
| busy | output | 1 | A movement is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Every result comes from registers. A start pulse shows up on busy, or on done for a zero length, one edge later. A satisfied transaction gate shows up on req_valid two edges later. The bubble after an accept lasts one edge, and done follows the final accept by one edge. The bench model advances on the same edges from the same inputs as the design. The design's outputs are compared with it 2 ns after each rising edge, so every output is checked in the cycle it is due to change and in every cycle it is due to hold. Accepted bursts are also checked against the burst limit, the 1 KB boundary, address continuity and the total length.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_GATE  = 2'd1,
    ST_CALC  = 2'd2,
    ST_ISSUE = 2'd3
  } dbs_state_e;
endpackage

// File: rtl/dbs_limits.sv
module dbs_limits #(
  parameter int CFG_W    = 8,
  parameter int RX_DEPTH = 64,
  parameter int TX_DEPTH = 32
) (
  input  logic             to_mem,
  input  logic [CFG_W-1:0] rd_burst,
  input  logic [CFG_W-1:0] wr_burst,
  input  logic [CFG_W-1:0] rx_txn,
  input  logic [CFG_W-1:0] tx_txn,
  output logic [CFG_W-1:0] txn_eff,
  output logic [CFG_W-1:0] burst_eff
);
  // index 0 = transmit side, index 1 = receive side
  logic [CFG_W-1:0] txn_c [2];
  logic [CFG_W-1:0] bst_c [2];

  for (genvar d = 0; d < 2; d++) begin : g_dir
    localparam int DEPTH = (d == 1) ? RX_DEPTH : TX_DEPTH;
    localparam logic [CFG_W-1:0] DEPTH_V = CFG_W'(DEPTH);
    logic [CFG_W-1:0] raw_txn;
    logic [CFG_W-1:0] raw_bst;
    logic [CFG_W-1:0] cl_txn;
    logic [CFG_W-1:0] cl_bst;

    assign raw_txn = (d == 1) ? rx_txn : tx_txn;
    assign raw_bst = (d == 1) ? wr_burst : rd_burst;

    always_comb begin
      if (raw_txn == '0)          cl_txn = CFG_W'(1);
      else if (raw_txn > DEPTH_V) cl_txn = DEPTH_V;
      else                        cl_txn = raw_txn;

      if (raw_bst == '0)          cl_bst = CFG_W'(1);
      else if (raw_bst > DEPTH_V) cl_bst = DEPTH_V;
      else                        cl_bst = raw_bst;
    end

    assign txn_c[d] = cl_txn;
    assign bst_c[d] = (cl_bst > cl_txn) ? cl_txn : cl_bst;
  end

  assign txn_eff   = to_mem ? txn_c[1] : txn_c[0];
  assign burst_eff = to_mem ? bst_c[1] : bst_c[0];
endmodule

// File: rtl/dbs_gate.sv
module dbs_gate #(
  parameter int LEN_W = 16,
  parameter int CFG_W = 8
) (
  input  logic             to_mem,
  input  logic [LEN_W-1:0] remaining,
  input  logic [CFG_W-1:0] txn_eff,
  input  logic [CFG_W-1:0] rx_level,
  input  logic             rx_eof,
  input  logic [CFG_W-1:0] tx_free,
  output logic             go,
  output logic [CFG_W-1:0] txn_len
);
  logic [CFG_W-1:0] full_len;
  logic [CFG_W-1:0] flush_len;

  always_comb begin
    if (remaining < LEN_W'(txn_eff)) full_len = CFG_W'(remaining);
    else                             full_len = txn_eff;

    if (remaining < LEN_W'(rx_level)) flush_len = CFG_W'(remaining);
    else                              flush_len = rx_level;
  end

  always_comb begin
    go      = 1'b0;
    txn_len = full_len;
    if (to_mem) begin
      if (rx_level >= txn_eff) begin
        go = 1'b1;
      end else if (rx_eof && (rx_level != '0)) begin
        go      = 1'b1;
        txn_len = flush_len;
      end
    end else begin
      go = (tx_free >= full_len);
    end
  end
endmodule

// File: rtl/dbs_burst_calc.sv
module dbs_burst_calc #(
  parameter int ADDR_W      = 32,
  parameter int CFG_W       = 8,
  parameter int BOUND_BYTES = 1024
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [CFG_W-1:0]  txn_rem,
  input  logic [CFG_W-1:0]  burst_eff,
  output logic [CFG_W-1:0]  blen
);
  localparam int OFF_W = $clog2(BOUND_BYTES);
  localparam int CW    = ((CFG_W > OFF_W) ? CFG_W : OFF_W) + 1;

  logic [CW-1:0]    room;
  logic [CFG_W-1:0] m1;

  assign room = CW'(BOUND_BYTES / 4) - CW'(addr[OFF_W-1:2]);

  always_comb begin
    m1 = (txn_rem < burst_eff) ? txn_rem : burst_eff;
    if (CW'(m1) < room) blen = m1;
    else                blen = CFG_W'(room);
  end
endmodule

// File: rtl/dma_burst_splitter.sv
module dma_burst_splitter #(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 16,
  parameter int CFG_W       = 8,
  parameter int RX_DEPTH    = 64,
  parameter int TX_DEPTH    = 32,
  parameter int BOUND_BYTES = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              to_mem,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  length,
  input  logic [CFG_W-1:0]  cfg_rd_burst,
  input  logic [CFG_W-1:0]  cfg_wr_burst,
  input  logic [CFG_W-1:0]  cfg_rx_txn,
  input  logic [CFG_W-1:0]  cfg_tx_txn,
  input  logic [CFG_W-1:0]  rx_level,
  input  logic              rx_eof,
  input  logic [CFG_W-1:0]  tx_free,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [CFG_W-1:0]  req_len,
  output logic              req_write,
  output logic              busy,
  output logic              done
);
  import dbs_pkg::*;

  dbs_state_e       state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic [CFG_W-1:0]  trem_q, trem_d;
  logic [CFG_W-1:0]  len_q, len_d;
  logic              done_q, done_d;

  logic              cfg_en;
  logic              dir_q;
  logic [CFG_W-1:0]  rdb_q, wrb_q, rxt_q, txt_q;

  logic [CFG_W-1:0]  txn_eff, burst_eff;
  logic              gate_go;
  logic [CFG_W-1:0]  gate_len;
  logic [CFG_W-1:0]  calc_len;
  logic [ADDR_W-1:0] step;

  dbs_limits #(
    .CFG_W   (CFG_W),
    .RX_DEPTH(RX_DEPTH),
    .TX_DEPTH(TX_DEPTH)
  ) u_limits (
    .to_mem   (dir_q),
    .rd_burst (rdb_q),
    .wr_burst (wrb_q),
    .rx_txn   (rxt_q),
    .tx_txn   (txt_q),
    .txn_eff  (txn_eff),
    .burst_eff(burst_eff)
  );

  dbs_gate #(
    .LEN_W(LEN_W),
    .CFG_W(CFG_W)
  ) u_gate (
    .to_mem   (dir_q),
    .remaining(rem_q),
    .txn_eff  (txn_eff),
    .rx_level (rx_level),
    .rx_eof   (rx_eof),
    .tx_free  (tx_free),
    .go       (gate_go),
    .txn_len  (gate_len)
  );

  dbs_burst_calc #(
    .ADDR_W     (ADDR_W),
    .CFG_W      (CFG_W),
    .BOUND_BYTES(BOUND_BYTES)
  ) u_calc (
    .addr     (addr_q),
    .txn_rem  (trem_q),
    .burst_eff(burst_eff),
    .blen     (calc_len)
  );

  assign step = ADDR_W'({len_q, 2'b00});

  // next-state logic
  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    rem_d   = rem_q;
    trem_d  = trem_q;
    len_d   = len_q;
    done_d  = 1'b0;
    cfg_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          cfg_en = 1'b1;
          addr_d = {start_addr[ADDR_W-1:2], 2'b00};
          rem_d  = length;
          if (length == '0) done_d  = 1'b1;
          else              state_d = ST_GATE;
        end
      end
      ST_GATE: begin
        if (gate_go) begin
          trem_d  = gate_len;
          state_d = ST_CALC;
        end
      end
      ST_CALC: begin
        len_d   = calc_len;
        state_d = ST_ISSUE;
      end
      ST_ISSUE: begin
        if (req_ready) begin
          addr_d = addr_q + step;
          rem_d  = rem_q - LEN_W'(len_q);
          trem_d = trem_q - len_q;
          if (rem_q == LEN_W'(len_q)) begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else if (trem_q == len_q) begin
            state_d = ST_GATE;
          end else begin
            state_d = ST_CALC;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // working registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
      trem_q  <= '0;
      len_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      rem_q   <= rem_d;
      trem_q  <= trem_d;
      len_q   <= len_d;
      done_q  <= done_d;
    end
  end

  // configuration captured at start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= 1'b0;
      rdb_q <= '0;
      wrb_q <= '0;
      rxt_q <= '0;
      txt_q <= '0;
    end else if (cfg_en) begin
      dir_q <= to_mem;
      rdb_q <= cfg_rd_burst;
      wrb_q <= cfg_wr_burst;
      rxt_q <= cfg_rx_txn;
      txt_q <= cfg_tx_txn;
    end
  end

  assign req_valid = (state_q == ST_ISSUE);
  assign req_addr  = addr_q;
  assign req_len   = len_q;
  assign req_write = dir_q;
  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
endmodule

// File: rtl/dbs_checker.sv
module dbs_checker #(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 16,
  parameter int CFG_W       = 8,
  parameter int RX_DEPTH    = 64,
  parameter int TX_DEPTH    = 32,
  parameter int BOUND_BYTES = 1024
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [LEN_W-1:0]  length,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [CFG_W-1:0]  req_len,
  input logic              req_write,
  input logic              busy,
  input logic              done
);
  localparam int OFF_W = $clog2(BOUND_BYTES);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_len) && $stable(req_write));

  p_len_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_len != '0) && (int'(req_len) <= (req_write ? RX_DEPTH : TX_DEPTH)));

  p_no_cross_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (int'(req_addr[OFF_W-1:2]) + int'(req_len)) <= (BOUND_BYTES / 4));

  p_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_addr[1:0] == 2'b00);

  p_bubble_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_valid);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !req_valid);

  p_zero_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && (length == '0) |=> done && !req_valid);
endmodule

bind dma_burst_splitter dbs_checker #(
  .ADDR_W     (ADDR_W),
  .LEN_W      (LEN_W),
  .CFG_W      (CFG_W),
  .RX_DEPTH   (RX_DEPTH),
  .TX_DEPTH   (TX_DEPTH),
  .BOUND_BYTES(BOUND_BYTES)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .length   (length),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_addr (req_addr),
  .req_len  (req_len),
  .req_write(req_write),
  .busy     (busy),
  .done     (done)
);

// File: tb/dma_burst_splitter_tb.sv
`timescale 1ns/1ps
module dma_burst_splitter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        to_mem = 1'b0;
  logic [31:0] start_addr = '0;
  logic [15:0] length = '0;
  logic [7:0]  cfg_rd_burst = '0, cfg_wr_burst = '0, cfg_rx_txn = '0, cfg_tx_txn = '0;
  logic [7:0]  rx_level = '0, tx_free = '0;
  logic        rx_eof = 1'b0;
  logic        req_ready = 1'b0;
  logic        req_valid, req_write, busy, done;
  logic [31:0] req_addr;
  logic [7:0]  req_len;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit ended = 0;

  always #2.5 clk = ~clk;

  dma_burst_splitter u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .to_mem(to_mem),
    .start_addr(start_addr), .length(length),
    .cfg_rd_burst(cfg_rd_burst), .cfg_wr_burst(cfg_wr_burst),
    .cfg_rx_txn(cfg_rx_txn), .cfg_tx_txn(cfg_tx_txn),
    .rx_level(rx_level), .rx_eof(rx_eof), .tx_free(tx_free),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len(req_len), .req_write(req_write), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  function automatic int clampi(input int v, input int d);
    if (v == 0) return 1;
    if (v > d) return d;
    return v;
  endfunction

  function automatic int mini(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  // ready pattern
  logic [15:0] lfsr = 16'hACE1;
  bit ready_always = 1;
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    req_ready <= ready_always ? 1'b1 : lfsr[0];
  end

  // behavioural reference model
  int          ms = 0;
  logic [31:0] maddr = '0;
  int          mrem = 0, mtrem = 0, mlen = 0;
  bit          mdone = 0, mdir = 0;
  int          m_txn = 1, m_blim = 1;

  always @(posedge clk) begin
    bit nd;
    int full, room;
    nd = 0;
    if (!rst_n) begin
      ms = 0; mdone = 0;
    end else begin
      case (ms)
        0: if (start) begin
          mdir  = to_mem;
          maddr = {start_addr[31:2], 2'b00};
          mrem  = int'(length);
          if (to_mem) begin
            m_txn  = clampi(int'(cfg_rx_txn), 64);
            m_blim = mini(clampi(int'(cfg_wr_burst), 64), m_txn);
          end else begin
            m_txn  = clampi(int'(cfg_tx_txn), 32);
            m_blim = mini(clampi(int'(cfg_rd_burst), 32), m_txn);
          end
          if (mrem == 0) nd = 1; else ms = 1;
        end
        1: begin
          full = mini(mrem, m_txn);
          if (mdir) begin
            if (int'(rx_level) >= m_txn) begin mtrem = full; ms = 2; end
            else if (rx_eof && rx_level != 0) begin mtrem = mini(mrem, int'(rx_level)); ms = 2; end
          end else if (int'(tx_free) >= full) begin
            mtrem = full; ms = 2;
          end
        end
        2: begin
          room = (1024 - int'(maddr % 1024)) / 4;
          mlen = mini(mini(mtrem, m_blim), room);
          ms = 3;
        end
        default: if (req_ready) begin
          maddr = maddr + 32'(mlen * 4);
          mrem  = mrem - mlen;
          mtrem = mtrem - mlen;
          if (mrem == 0) begin nd = 1; ms = 0; end
          else if (mtrem == 0) ms = 1;
          else ms = 2;
        end
      endcase
      mdone = nd;
    end
  end

  // per-cycle comparison plus accepted-burst monitor
  int          cur_lim = 64;
  logic [31:0] exp_next = '0;
  int          sum_words = 0;
  bit          s_acc;
  logic [31:0] s_addr;
  int          s_len;

  always @(posedge clk) begin
    cyc++;
    s_acc  = rst_n && req_valid && req_ready;
    s_addr = req_addr;
    s_len  = int'(req_len);
    #2;
    if (rst_n) begin
      chk(req_valid == (ms == 3), "R8 req_valid timing", longint'(req_valid), longint'(ms == 3));
      chk(busy == (ms != 0), "R11 busy", longint'(busy), longint'(ms != 0));
      chk(done == mdone, "R9 done", longint'(done), longint'(mdone));
      if (ms == 3) begin
        chk(req_addr == maddr, "R4 req_addr", longint'(req_addr), longint'(maddr));
        chk(int'(req_len) == mlen, "R3 req_len", longint'(req_len), longint'(mlen));
        chk(req_write == mdir, "R7 req_write", longint'(req_write), longint'(mdir));
      end
      if (s_acc) begin
        chk(s_len >= 1 && s_len <= cur_lim, "R2 burst limit", s_len, cur_lim);
        chk(int'(s_addr % 1024) / 4 + s_len <= 256, "R3 1KB crossing", s_len, 256 - int'(s_addr % 1024) / 4);
        chk(s_addr == exp_next, "R4 continuity", longint'(s_addr), longint'(exp_next));
        exp_next  = s_addr + 32'(s_len * 4);
        sum_words = sum_words + s_len;
      end
    end
    if (cyc > 150000) begin
      chk(0, "watchdog", cyc, 150000);
      finish_run();
    end
  end

  task automatic kick(input bit dir, input logic [31:0] a, input int len,
                      input int rdb, input int wrb, input int rxt, input int txt, input int lim);
    @(negedge clk);
    to_mem = dir; start_addr = a; length = 16'(len);
    cfg_rd_burst = 8'(rdb); cfg_wr_burst = 8'(wrb);
    cfg_rx_txn = 8'(rxt); cfg_tx_txn = 8'(txt);
    cur_lim = lim; exp_next = {a[31:2], 2'b00}; sum_words = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input int len);
    bit got;
    got = 0;
    for (int i = 0; i < 5000; i++) begin
      if (done) begin got = 1; break; end
      @(negedge clk);
    end
    chk(got, "R9 done reached", longint'(got), 1);
    chk(sum_words == len, "R9 total length", sum_words, len);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(req_valid == 0 && busy == 0 && done == 0, "R1 reset state",
        longint'({req_valid, busy, done}), 0);
    repeat (2) @(negedge clk);
    chk(req_valid == 0 && busy == 0, "R1 idle after reset", longint'({req_valid, busy}), 0);

    // transmit, plain split by burst limit
    tx_free = 8'd32;
    kick(0, 32'h0000_1000, 100, 16, 4, 4, 32, 16);
    wait_done(100);

    // transmit across a 1 KB boundary, oversized burst setting clamped
    kick(0, 32'h0000_13F0, 40, 64, 1, 1, 8, 8);
    wait_done(40);

    // receive, oversized write burst and zero transaction size, ready toggling
    ready_always = 0;
    rx_level = 8'd64;
    kick(1, 32'h0000_2003, 20, 1, 200, 0, 1, 1);
    wait_done(20);

    // receive with large sizes crossing a boundary
    kick(1, 32'h0000_23C0, 150, 1, 40, 64, 1, 40);
    wait_done(150);
    ready_always = 1;

    // receive gated on FIFO level (R5)
    rx_level = 8'd5;
    kick(1, 32'h0000_3000, 50, 1, 8, 16, 1, 8);
    for (int i = 0; i < 12; i++) begin
      chk(req_valid == 0, "R5 held below threshold", longint'(req_valid), 0);
      @(negedge clk);
    end
    rx_level = 8'd16;
    wait_done(50);

    // receive flushed at end of frame (R5)
    rx_level = 8'd4;
    kick(1, 32'h0000_4000, 10, 1, 16, 16, 1, 16);
    for (int i = 0; i < 10; i++) begin
      chk(req_valid == 0, "R5 no flush without frame end", longint'(req_valid), 0);
      @(negedge clk);
    end
    rx_eof = 1'b1;
    wait_done(10);
    rx_eof = 1'b0;

    // transmit gated on free space (R6)
    tx_free = 8'd3;
    kick(0, 32'h0000_5000, 20, 8, 1, 1, 8, 8);
    for (int i = 0; i < 12; i++) begin
      chk(req_valid == 0, "R6 held without room", longint'(req_valid), 0);
      @(negedge clk);
    end
    tx_free = 8'd32;
    wait_done(20);

    // final transmit transaction shorter than size only needs its own room (R6)
    tx_free = 8'd4;
    kick(0, 32'h0000_5800, 3, 8, 1, 1, 8, 8);
    wait_done(3);
    tx_free = 8'd32;

    // zero length (R10)
    kick(0, 32'h0000_6000, 0, 8, 8, 8, 8, 8);
    #3;
    chk(busy == 0 && req_valid == 0, "R10 no request for zero length",
        longint'({busy, req_valid}), 0);
    @(negedge clk);

    // start while busy is ignored (R11)
    ready_always = 0;
    kick(0, 32'h0000_7000, 30, 4, 1, 1, 8, 4);
    repeat (3) @(negedge clk);
    start_addr = 32'h0000_9000; length = 16'd5; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(30);
    chk(exp_next == 32'h0000_7000 + 32'd120, "R11 original movement completed",
        longint'(exp_next), longint'(32'h0000_7078));
    ready_always = 1;

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule